// File: doc/BRIEF.md
# Truth-Table-Programmed Logical Unit

This block is a purely combinational bitwise logic unit. It applies one two-input Boolean function to every bit position of two operand words. The function is named by a 4-bit code, and that code is the truth table of the function. The bit pair at each position picks one code bit, and the picked bit is that position's result. All sixteen two-input functions can be selected, including constants, pass-through of either operand, complements, AND, OR, XOR, their inverses, implications and inhibitions. No opcode decoder is needed.

An enable input switches the whole unit on or off. When it is off, the result is all zeros, so the unit can share a result bus with other datapath units through an OR. The word width is a parameter. A second parameter chooses how each per-bit selector is built. Both builds give the same function.

Top module: `tt_logic_unit`

## Requirements
- R1: With `enable_i` high, each result bit `result_o[i]` equals `func_code_i[k]`, where k = 2*`op_a_i[i]` + `op_b_i[i]`. This holds for every one of the 16 codes.
- R2: Each bit position is evaluated independently. Mixed operand patterns give per-bit results that depend only on that position's two operand bits.
- R3: Code 4'b1110 gives the bitwise OR of the operands, and code 4'b0111 gives the bitwise NAND.
- R4: Code 4'b1000 gives AND, 4'b0110 gives XOR, 4'b1100 passes `op_a_i`, 4'b1010 passes `op_b_i`, and 4'b0011 gives the complement of `op_a_i`.
- R5: Code 4'b0000 gives all zeros and code 4'b1111 gives all ones, whatever the operands.
- R6: With `enable_i` low, every result bit is 0, whatever the code and the operands.
- R7: The result follows any change of the inputs in the same cycle. No register lies on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a_i | input | WIDTH | First operand; high select bit of each slice |
| op_b_i | input | WIDTH | Second operand; low select bit of each slice |
| func_code_i | input | 4 | Truth-table column; bit k is the output for operand pair value k |
| enable_i | input | 1 | Unit enable; low forces the result to zero |
| result_o | output | WIDTH | Bitwise result |

## Verification
The block holds no state. A fault in one slice's selector, such as swapped select lines or a wrong data tap, therefore shows at once on the matching result bit. It shows only for the codes and operand pairs that tell the two mappings apart. A swap of A and B, for example, is hidden by symmetric codes such as AND and XOR, but it shows with the code that passes A alone. For this reason every code is driven with operands that cover all four bit-pair values, and each result is compared in the same cycle that the inputs change. A broken enable gate shows on the first disabled vector whose operands would otherwise give a nonzero result.

// File: rtl/tt_lu_pkg.sv
// Package: shared code type and named function codes for the logical unit.
// Assumes: code bit k is the result for operand pair value k = {a,b}.
package tt_lu_pkg;
    typedef logic [3:0] lu_code_t;

    localparam lu_code_t FN_ZERO  = 4'b0000;
    localparam lu_code_t FN_AND   = 4'b1000;
    localparam lu_code_t FN_XOR   = 4'b0110;
    localparam lu_code_t FN_OR    = 4'b1110;
    localparam lu_code_t FN_NAND  = 4'b0111;
    localparam lu_code_t FN_PASSA = 4'b1100;
    localparam lu_code_t FN_PASSB = 4'b1010;
    localparam lu_code_t FN_NOTA  = 4'b0011;
    localparam lu_code_t FN_ONE   = 4'b1111;

    // Build variants for the per-bit selector.
    localparam int SLICE_INDEXED = 0;
    localparam int SLICE_TREE    = 1;
endpackage

// File: rtl/lu_bit_slice.sv
// Module: one bit of the logical unit. It is a 4-to-1 selector whose data inputs
// are the function code and whose selects are the two operand bits.
// Assumes: IMPL picks an indexed selector or a two-level 2:1 tree. Both are
// functionally identical.
module lu_bit_slice
    import tt_lu_pkg::*;
#(
    parameter int IMPL = SLICE_INDEXED
) (
    input  logic     a_bit,
    input  logic     b_bit,
    input  lu_code_t code,
    output logic     y_bit
);
    generate
        if (IMPL == SLICE_TREE) begin : g_tree
            logic lo_pick;
            logic hi_pick;
            // First level: b chooses within each half of the code.
            always_comb begin
                lo_pick = b_bit ? code[1] : code[0];
                hi_pick = b_bit ? code[3] : code[2];
            end
            // Second level: a chooses between the halves.
            always_comb y_bit = a_bit ? hi_pick : lo_pick;
        end else begin : g_indexed
            // Direct index of the code by the operand pair.
            always_comb y_bit = code[{a_bit, b_bit}];
        end
    endgenerate
endmodule

// File: rtl/lu_output_gate.sv
// Module: enable gate on the result word. It forces zeros when the unit is off,
// so results from several units can be merged by OR.
// Assumes: enable is active high.
module lu_output_gate #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] raw,
    input  logic             en,
    output logic [WIDTH-1:0] gated
);
    // Mask every bit with the enable.
    always_comb gated = raw & {WIDTH{en}};
endmodule

// File: rtl/tt_logic_unit.sv
// Module: bitwise logical unit programmed by a 4-bit truth-table code.
// It has one slice per bit and one gate on the whole word. It is fully
// combinational.
// Assumes: WIDTH >= 1. The same code drives every slice.
module tt_logic_unit
    import tt_lu_pkg::*;
#(
    parameter int WIDTH      = 16,
    parameter int SLICE_IMPL = SLICE_INDEXED
) (
    input  logic [WIDTH-1:0] op_a_i,
    input  logic [WIDTH-1:0] op_b_i,
    input  logic [3:0]       func_code_i,
    input  logic             enable_i,
    output logic [WIDTH-1:0] result_o
);
    localparam int LAST_BIT = WIDTH - 1;

    lu_code_t           code_w;
    logic [LAST_BIT:0]  slice_out;

    // Present the code in the shared type to every slice.
    always_comb code_w = lu_code_t'(func_code_i);

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        lu_bit_slice #(.IMPL(SLICE_IMPL)) u_slice (
            .a_bit (op_a_i[i]),
            .b_bit (op_b_i[i]),
            .code  (code_w),
            .y_bit (slice_out[i])
        );
    end

    lu_output_gate #(.WIDTH(WIDTH)) u_gate (
        .raw   (slice_out),
        .en    (enable_i),
        .gated (result_o)
    );
endmodule

// File: rtl/tt_logic_unit_chk.sv
// Checker: immediate assertions on the ports of tt_logic_unit, bound below.
// Assumes: the inputs settle before the checker evaluates, which holds because
// the block is combinational.
module tt_logic_unit_chk #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0] op_a_i,
    input logic [WIDTH-1:0] op_b_i,
    input logic [3:0]       func_code_i,
    input logic             enable_i,
    input logic [WIDTH-1:0] result_o
);
    // Port-level properties, re-evaluated whenever any port changes.
    always_comb begin
        if (enable_i === 1'b0) begin
            a_r6_disabled_zero: assert (result_o == '0);
        end
        if (enable_i === 1'b1 && func_code_i == 4'b1110) begin
            a_r3_or: assert (result_o == (op_a_i | op_b_i));
        end
        if (enable_i === 1'b1 && func_code_i == 4'b0111) begin
            a_r3_nand: assert (result_o == ~(op_a_i & op_b_i));
        end
        if (enable_i === 1'b1 && func_code_i == 4'b1000) begin
            a_r4_and: assert (result_o == (op_a_i & op_b_i));
        end
        if (enable_i === 1'b1 && func_code_i == 4'b1111) begin
            a_r5_all_ones: assert (result_o == '1);
        end
        if (func_code_i == 4'b0000) begin
            a_r5_all_zero: assert (result_o == '0);
        end
    end
endmodule

bind tt_logic_unit tt_logic_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .op_a_i      (op_a_i),
    .op_b_i      (op_b_i),
    .func_code_i (func_code_i),
    .enable_i    (enable_i),
    .result_o    (result_o)
);

// File: tb/sim_tt_logic_unit.sv
module sim_tt_logic_unit;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a, b, f;
    logic [3:0]   code;
    logic         en;
    int checks = 0;
    int fails  = 0;
    bit done = 1'b0;

    tt_logic_unit #(.WIDTH(W)) u0 (
        .op_a_i(a), .op_b_i(b), .func_code_i(code), .enable_i(en), .result_o(f)
    );

    always #2.5 clk = ~clk;

    // Reference built from the truth-table definition, position by position.
    function automatic logic [W-1:0] ref_f(logic [W-1:0] ra, logic [W-1:0] rb,
                                           logic [3:0] rc, logic re);
        logic [W-1:0] r;
        r = '0;
        for (int i = 0; i < W; i++) begin
            int k;
            k = (ra[i] ? 2 : 0) + (rb[i] ? 1 : 0);
            r[i] = re & rc[k];
        end
        return r;
    endfunction

    task automatic check(string req, logic [W-1:0] exp);
        checks++;
        if (f !== exp) begin
            fails++;
            $display("FAIL %s code=%b en=%b a=%h b=%h got=%h exp=%h",
                     req, code, en, a, b, f, exp);
        end
    endtask

    // Drive away from the rising edge; sample 1 ns later (combinational path).
    task automatic apply(logic [W-1:0] ta, logic [W-1:0] tb, logic [3:0] tc, logic te);
        @(negedge clk);
        a = ta; b = tb; code = tc; en = te;
        #1;
    endtask

    initial begin
        a = '0; b = '0; code = 4'b0000; en = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        #1;
        check("R6 reset state", '0);

        // R1: every code with operands that cover all four pair values, then random.
        for (int c = 0; c < 16; c++) begin
            apply(16'hFF00, 16'hF0F0, 4'(c), 1'b1);
            check("R1 sweep fixed", ref_f(a, b, code, 1'b1));
            for (int r = 0; r < 8; r++) begin
                apply(16'($urandom), 16'($urandom), 4'(c), 1'b1);
                check("R1 sweep random", ref_f(a, b, code, 1'b1));
            end
        end

        // R2: a mixed pattern where each bit position has its own pair.
        apply(16'b1100_1010_0110_0001, 16'b1010_0110_1100_1000, 4'b0110, 1'b1);
        check("R2 per-bit XOR", 16'b0110_1100_1010_1001);

        // R3: OR and NAND, computed with plain operators.
        apply(16'h1234, 16'h0F0F, 4'b1110, 1'b1);
        check("R3 OR", 16'h1234 | 16'h0F0F);
        apply(16'h1234, 16'h0F0F, 4'b0111, 1'b1);
        check("R3 NAND", ~(16'h1234 & 16'h0F0F));

        // R4: named functions; PASSA separates a swap of the A and B selects.
        apply(16'hA5C3, 16'h3C5A, 4'b1000, 1'b1); check("R4 AND",   16'hA5C3 & 16'h3C5A);
        apply(16'hA5C3, 16'h3C5A, 4'b0110, 1'b1); check("R4 XOR",   16'hA5C3 ^ 16'h3C5A);
        apply(16'hA5C3, 16'h3C5A, 4'b1100, 1'b1); check("R4 PASSA", 16'hA5C3);
        apply(16'hA5C3, 16'h3C5A, 4'b1010, 1'b1); check("R4 PASSB", 16'h3C5A);
        apply(16'hA5C3, 16'h3C5A, 4'b0011, 1'b1); check("R4 NOTA",  ~16'hA5C3);

        // R5: constants.
        apply(16'hFFFF, 16'hFFFF, 4'b0000, 1'b1); check("R5 zero", 16'h0000);
        apply(16'h0000, 16'h0000, 4'b1111, 1'b1); check("R5 ones", 16'hFFFF);

        // R6: disabled unit outputs zero for codes that would give ones.
        apply(16'h0000, 16'h0000, 4'b1111, 1'b0); check("R6 off ones", '0);
        apply(16'hBEEF, 16'h1234, 4'b1110, 1'b0); check("R6 off OR", '0);
        apply(16'hBEEF, 16'h1234, 4'b1110, 1'b1); check("R6 re-enable", 16'hBEEF | 16'h1234);

        // R7: a code change without an edge is seen at once.
        #0.5 code = 4'b1000; #0.5;
        check("R7 same-cycle", 16'hBEEF & 16'h1234);

        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog expired got=running exp=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule